// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of an SPI controller from the module clock. A control word selects one of two division schemes. The linear scheme divides by an even number, 2*(N+1), where N is an 8-bit field. The power-of-two scheme divides by 2^(M+1), where M is a 4-bit field. The output always has a 50% duty cycle, because a counter toggles it at the end of every half-period.

The transfer engine raises `enable` to start the clock and lowers it to stop. While `enable` is low, the serial clock rests at a fixed idle level. The control word is captured only in the cycle where `enable` is first seen high, so a new setting takes effect at the next enable. Along with the clock, the block emits two one-cycle strobes. The shift engine uses these to find the leading edge (leaving idle) and the trailing edge (returning to idle) without detecting edges itself.

Top module: `sclkDiv`

## Requirements
- R1: While reset is asserted, `sclk` is 0 (the idle level) and both `leadStb` and `trailStb` are 0.
- R2: While `enable` is low, `sclk` is at idle and both strobes stay low from the cycle after `enable` is sampled low. Changes to `ctlWord` in that time have no visible effect.
- R3: When `ctlWord[12]` is 1 (linear mode), the half-period is N+1 module-clock cycles, where N is `ctlWord[7:0]`. The period is therefore 2*(N+1) cycles.
- R4: When `ctlWord[12]` is 0 (power-of-two mode), the half-period is 2^M cycles, where M is `ctlWord[11:8]`. The linear field is ignored in this mode.
- R5: In linear mode with N = 0, `sclk` toggles on every module-clock edge, giving the module clock divided by 2.
- R6: Suppose `enable` is first sampled high at edge k and the half-period is H. Then `sclk` first leaves idle at edge k+H.
- R7: `leadStb` is high for exactly the one cycle after `sclk` moves from idle to active. `trailStb` is high for exactly the one cycle after `sclk` returns to idle. The two are never high together.
- R8: The control word is captured at the edge where `enable` is first sampled high. Changes to it while `enable` stays high do not alter the running clock.
- R9: Suppose `enable` is sampled low at the same edge as a half-period terminal count. Then stopping wins: `sclk` goes to idle and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request from the transfer engine |
| ctlWord | input | 13 | Bits 7:0 linear divisor N, bits 11:8 power-of-two exponent M, bit 12 mode select (1 = linear) |
| sclk | output | 1 | Serial clock, 50% duty, idle level 0 |
| leadStb | output | 1 | One-cycle strobe after the leading serial clock edge |
| trailStb | output | 1 | One-cycle strobe after the trailing serial clock edge |

## Verification
Two things can land on the same edge. The first is dropping `enable` and the terminal count that would produce a trailing edge. The bench provokes this by releasing `enable` in the cycle before the terminal count of a high phase, then expects `sclk` at idle with no trailing strobe.

The second is a control-word change and the first sampled-high `enable`. The bench rewrites the word mid-run and then again around a restart. It judges from the measured strobe spacing which value was captured. A behavioural cycle model is also compared on every clock.

// File: rtl/sclkDivPkg.sv
package sclkDivPkg;

  // Commands from the control path to the counter/output datapath
  typedef struct packed {
    logic clear;  // stop: force idle, zero the counter
    logic load;   // first enabled cycle: zero the counter, config latched
    logic tick;   // running: advance the half-period counter
  } divCmd_t;

endpackage

// File: rtl/sclkDivCtrl.sv
module sclkDivCtrl
  import sclkDivPkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  localparam int POW_MAX = (1 << POW_W) - 1,
  localparam int HALF_W = (LIN_W > POW_MAX) ? LIN_W : POW_MAX,
  localparam int CTL_W = LIN_W + POW_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CTL_W-1:0]  ctlWord,
  output divCmd_t           cmd,
  output logic [HALF_W-1:0] halfM1
);

  logic              runQ;
  logic [HALF_W-1:0] halfQ;
  logic [LIN_W-1:0]  linField;
  logic [POW_W-1:0]  powField;
  logic              linSel;
  logic [POW_MAX-1:0] thermo;
  logic [HALF_W-1:0] halfNext;

  assign linField = ctlWord[LIN_W-1:0];
  assign powField = ctlWord[LIN_W +: POW_W];
  assign linSel   = ctlWord[CTL_W-1];

  // 2^M - 1 as a thermometer code: bit i set when M > i (no shifter needed)
  for (genvar i = 0; i < POW_MAX; i++) begin : g_thermo
    assign thermo[i] = (powField > POW_W'(i));
  end

  assign halfNext = linSel ? HALF_W'(linField) : HALF_W'(thermo);

  assign cmd.clear = !enable;
  assign cmd.load  = enable && !runQ;
  assign cmd.tick  = enable && runQ;
  assign halfM1    = halfQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      halfQ <= '0;
    end else begin
      runQ <= enable;
      if (cmd.load) halfQ <= halfNext;
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && $past(runQ)) |-> $stable(halfQ));

endmodule

// File: rtl/sclkDivPath.sv
module sclkDivPath
  import sclkDivPkg::*;
#(
  parameter int   HALF_W   = 15,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  divCmd_t           cmd,
  input  logic [HALF_W-1:0] halfM1,
  output logic              sclk,
  output logic              leadStb,
  output logic              trailStb
);

  logic [HALF_W-1:0] cntQ;
  logic              sclkQ;
  logic              leadQ;
  logic              trailQ;
  logic              term;

  assign term = (cntQ == halfM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      sclkQ  <= IDLE_LVL;
      leadQ  <= 1'b0;
      trailQ <= 1'b0;
    end else begin
      leadQ  <= 1'b0;
      trailQ <= 1'b0;
      if (cmd.clear) begin
        cntQ  <= '0;
        sclkQ <= IDLE_LVL;
      end else if (cmd.load) begin
        cntQ <= '0;
      end else if (cmd.tick) begin
        if (term) begin
          cntQ   <= '0;
          sclkQ  <= ~sclkQ;
          leadQ  <= (sclkQ == IDLE_LVL);
          trailQ <= (sclkQ != IDLE_LVL);
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end
  end

  assign sclk     = sclkQ;
  assign leadStb  = leadQ;
  assign trailStb = trailQ;

  // R2 / R9
  idle_after_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.clear) |-> (sclkQ == IDLE_LVL && !leadQ && !trailQ));

  // R7
  lead_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    leadQ |-> (sclkQ != IDLE_LVL && $past(sclkQ) == IDLE_LVL));

  // R7
  trail_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    trailQ |-> (sclkQ == IDLE_LVL && $past(sclkQ) != IDLE_LVL));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({leadQ, trailQ}));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= halfM1);

endmodule

// File: rtl/sclkDiv.sv
module sclkDiv
  import sclkDivPkg::*;
#(
  parameter int   LIN_W    = 8,
  parameter int   POW_W    = 4,
  parameter logic IDLE_LVL = 1'b0,
  localparam int  POW_MAX  = (1 << POW_W) - 1,
  localparam int  HALF_W   = (LIN_W > POW_MAX) ? LIN_W : POW_MAX,
  localparam int  CTL_W    = LIN_W + POW_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CTL_W-1:0] ctlWord,
  output logic             sclk,
  output logic             leadStb,
  output logic             trailStb
);

  divCmd_t           cmd;
  logic [HALF_W-1:0] halfM1;

  sclkDivCtrl #(.LIN_W(LIN_W), .POW_W(POW_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .ctlWord(ctlWord),
    .cmd(cmd), .halfM1(halfM1)
  );

  sclkDivPath #(.HALF_W(HALF_W), .IDLE_LVL(IDLE_LVL)) i_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .halfM1(halfM1),
    .sclk(sclk), .leadStb(leadStb), .trailStb(trailStb)
  );

endmodule

// File: tb/test_sclkDiv.sv
module test_sclkDiv;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [12:0] ctlWord = '0;
  logic        sclk, leadStb, trailStb;

  always #10 clk = ~clk;

  sclkDiv i_sclkDiv (
    .clk(clk), .rstN(rstN), .enable(enable), .ctlWord(ctlWord),
    .sclk(sclk), .leadStb(leadStb), .trailStb(trailStb)
  );

  int    nChecks = 0;
  int    nFail = 0;
  string phase = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int mRun = 0, mHalf = 1, mCnt = 0, mSclk = 0, mLead = 0, mTrail = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mCnt = 0; mSclk = 0; mLead = 0; mTrail = 0;
    end else begin
      mLead = 0; mTrail = 0;
      if (!enable) begin
        mRun = 0; mCnt = 0; mSclk = 0;
      end else if (mRun == 0) begin
        mRun = 1; mCnt = 0;
        mHalf = ctlWord[12] ? int'(ctlWord[7:0]) + 1 : (1 << ctlWord[11:8]);
      end else begin
        mCnt++;
        if (mCnt >= mHalf) begin
          mCnt = 0;
          mSclk = 1 - mSclk;
          if (mSclk == 1) mLead = 1; else mTrail = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(int'(sclk) == mSclk, phase, "model sclk", int'(sclk), mSclk);
      check(int'(leadStb) == mLead, phase, "model leadStb", int'(leadStb), mLead);
      check(int'(trailStb) == mTrail, phase, "model trailStb", int'(trailStb), mTrail);
    end
  end

  function automatic logic [12:0] linCfg(input int n);
    return {1'b1, 4'hA, 8'(n)};
  endfunction

  function automatic logic [12:0] powCfg(input int m);
    return {1'b0, 4'(m), 8'h5C};
  endfunction

  task automatic waitLead(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!leadStb && n < 5000);
  endtask

  task automatic waitTrail(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!trailStb && n < 5000);
  endtask

  // Start the clock, measure first edge, trailing distance and period, stop
  task automatic runCase(input logic [12:0] cfg, input int h, input string req);
    int n;
    phase = req;
    @(negedge clk);
    ctlWord = cfg;
    enable = 1'b1;
    waitLead(n);
    check(n == h + 1, "R6", {req, " first edge delay"}, n, h + 1);
    waitTrail(n);
    check(n == h, req, "lead to trail cycles", n, h);
    waitLead(n);
    check(n == h, req, "trail to lead cycles", n, h);
    waitLead(n);
    check(n == 2 * h, req, "period cycles", n, 2 * h);
    enable = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0 && !leadStb && !trailStb, "R2", "idle after stop",
          int'(sclk), 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
    check(!leadStb && !trailStb, "R1", "strobes in reset",
          int'({leadStb, trailStb}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runCase(linCfg(3), 4, "R3");
    runCase(linCfg(0), 1, "R5");
    runCase(linCfg(255), 256, "R3");
    runCase(powCfg(3), 8, "R4");
    runCase(powCfg(0), 1, "R4");
    runCase(powCfg(5), 32, "R4");

    // R2: control word changes while disabled leave everything idle
    phase = "R2";
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ctlWord = (i % 2 == 0) ? linCfg(i) : powCfg(i % 16);
      check(sclk == 1'b0 && !leadStb && !trailStb, "R2", "idle while disabled",
            int'({sclk, leadStb, trailStb}), 0);
    end

    // R8: mid-run change ignored, captured at next enable
    phase = "R8";
    @(negedge clk);
    ctlWord = linCfg(2);
    enable = 1'b1;
    waitLead(n);
    ctlWord = linCfg(9);
    waitLead(n);
    check(n == 6, "R8", "period after mid-run change", n, 6);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    waitLead(n);
    check(n == 11, "R8", "first edge with new config", n, 11);
    waitLead(n);
    check(n == 20, "R8", "period with new config", n, 20);
    enable = 1'b0;
    repeat (2) @(negedge clk);

    // R9: stop on the same edge as the trailing terminal count
    phase = "R9";
    ctlWord = linCfg(1);
    enable = 1'b1;
    waitLead(n);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R9", "sclk idle on stop at terminal", int'(sclk), 0);
    check(!trailStb && !leadStb, "R9", "no strobe on stop at terminal",
          int'({leadStb, trailStb}), 0);
    repeat (4) @(negedge clk);

    finishRun();
  end

endmodule